// File: doc/BRIEF.md
# Raster Scan Timing Generator

This block produces the sync, blanking and data-enable strobes for a parallel RGB panel. Software writes the sync width, back porch, active size and front porch for both directions through a simple write port, then sets a run bit. From then on the block steps a pixel counter and a line counter on each pixel-clock enable. Both counters are visible at the ports.

A sticky event flag drives the interrupt line. The flag is set once per frame at a line picked by a select field: the start of vertical sync, the start of the vertical back porch, the first active line, or a programmable line number. Software clears the flag by writing a one to it. A soft-reset bit in the control register stops scan-out at once and clears the counters and the flag.

All strobes are active high. Every timing field holds its count minus one, so a field of zero means one line or one pixel.

Top module: `scan_timing_gen`

## Requirements
- R1: Registers are written with `wr_en`. Each timing field holds its count minus one. Addresses: 2 holds vertical back porch in [11:0] and vertical front porch in [27:16]. 3 holds vertical sync width in [11:0]. 4 holds horizontal back porch in [11:0] and horizontal front porch in [27:16]. 5 holds horizontal sync width in [11:0]. 6 holds active width in [11:0] and active height in [27:16]. 7 holds the line threshold in [11:0].
- R2: Within a line, the pixel order is sync, back porch, active, front porch, starting from pixel 0. The lines of a frame follow the same order, starting from line 0. `hsync` is high during the horizontal sync pixels and `vsync` is high during the vertical sync lines.
- R3: `de` is high only when the pixel and the line both fall in their active regions. `hblank` and `vblank` are the inverse of the horizontal and vertical active regions.
- R4: `pix_cnt` runs from 0 to the line total minus one, and `line_cnt` runs from 0 to the frame total minus one. Both counters advance only on cycles where `pix_ce` is high.
- R5: Address 0 bit 0 is the run bit. While the block is idle, the counters read zero, sync is low, and both blanks are high. Scan-out starts on the first `pix_ce` after the run bit is set. Clearing the run bit takes effect at the end of the current frame.
- R6: The flag, shown on `irq`, can be set only when the global enable (address 1 bit 0) and the frame enable (address 1 bit 1) are both one. It is set on the clock edge that ends pixel 0 of the selected line.
- R7: The select field at address 1 bits [3:2] picks the line that sets the flag: 0 is line 0 (start of vsync), 1 is the first back-porch line, 2 is the first active line, and 3 is the threshold line.
- R8: Writing address 8 with bit 0 set clears the flag. Writing a zero there has no effect. If the flag is set and cleared in the same cycle, the set takes priority.
- R9: Writing address 0 with bit 1 set clears the run bit, both counters and the flag on that same clock edge. Bit 0 of that write is ignored.
- R10: With select value 3, the flag rises at pixel 0 of the line whose number equals the threshold field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_ce | input | 1 | Pixel-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | DW | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| de | output | 1 | Active video |
| irq | output | 1 | Sticky event flag |
| pix_cnt | output | FW+2 | Current pixel in line |
| line_cnt | output | FW+2 | Current line in frame |

## Verification
The assertions take two things for granted. Timing fields change only while the block is idle or at a safe point, so the counters never go past a total that has just shrunk. Writes arrive one at a time, each lasting a single cycle. The stimulus meets both conditions: it programs every field before setting the run bit and leaves the geometry alone afterwards. It changes only the interrupt-control, status and control registers while scan-out is running. The pixel enable is stepped in three patterns: always high, random, and held low.

// File: rtl/scan_timing_gen.sv
module scan_timing_gen #(
  parameter int FW = 12,
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int CW = FW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_ce,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          hblank,
  output logic          vblank,
  output logic          de,
  output logic          irq,
  output logic [CW-1:0] pix_cnt,
  output logic [CW-1:0] line_cnt
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_INTC = AW'(1);
  localparam logic [AW-1:0] A_VPOR = AW'(2);
  localparam logic [AW-1:0] A_VSW  = AW'(3);
  localparam logic [AW-1:0] A_HPOR = AW'(4);
  localparam logic [AW-1:0] A_HSW  = AW'(5);
  localparam logic [AW-1:0] A_SIZE = AW'(6);
  localparam logic [AW-1:0] A_THR  = AW'(7);
  localparam logic [AW-1:0] A_STAT = AW'(8);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic          en_q, gie_q, fie_q, run_q, flag_q;
  logic [1:0]    fsel_q;
  logic [FW-1:0] vbp_q, vfp_q, vsw_q, hbp_q, hfp_q, hsw_q, hact_q, vact_q, thr_q;
  logic [CW-1:0] pix_q, line_q, tgt;

  wire [FW-1:0] lo_f = wr_data[FW-1:0];
  wire [FW-1:0] hi_f = wr_data[16 +: FW];

  wire [CW-1:0] hs_end = CW'(hsw_q) + ONE;
  wire [CW-1:0] hb_end = hs_end + CW'(hbp_q) + ONE;
  wire [CW-1:0] ha_end = hb_end + CW'(hact_q) + ONE;
  wire [CW-1:0] h_last = ha_end + CW'(hfp_q);
  wire [CW-1:0] vs_end = CW'(vsw_q) + ONE;
  wire [CW-1:0] vb_end = vs_end + CW'(vbp_q) + ONE;
  wire [CW-1:0] va_end = vb_end + CW'(vact_q) + ONE;
  wire [CW-1:0] v_last = va_end + CW'(vfp_q);

  always_comb begin
    case (fsel_q)
      2'd0:    tgt = '0;
      2'd1:    tgt = vs_end;
      2'd2:    tgt = vb_end;
      default: tgt = CW'(thr_q);
    endcase
  end

  wire srst   = wr_en && wr_addr == A_CTRL && wr_data[1];
  wire clr    = wr_en && wr_addr == A_STAT && wr_data[0];
  wire ev_hit = run_q && pix_ce && pix_q == '0 && line_q == tgt;
  wire ev_set = ev_hit && gie_q && fie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; gie_q <= 1'b0; fie_q <= 1'b0; fsel_q <= '0;
      vbp_q <= '0; vfp_q <= '0; vsw_q <= '0; hbp_q <= '0; hfp_q <= '0;
      hsw_q <= '0; hact_q <= '0; vact_q <= '0; thr_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: en_q <= wr_data[0] && !wr_data[1];
        A_INTC: begin gie_q <= wr_data[0]; fie_q <= wr_data[1]; fsel_q <= wr_data[3:2]; end
        A_VPOR: begin vbp_q <= lo_f; vfp_q <= hi_f; end
        A_VSW:  vsw_q <= lo_f;
        A_HPOR: begin hbp_q <= lo_f; hfp_q <= hi_f; end
        A_HSW:  hsw_q <= lo_f;
        A_SIZE: begin hact_q <= lo_f; vact_q <= hi_f; end
        A_THR:  thr_q <= lo_f;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; pix_q <= '0; line_q <= '0;
    end else if (srst) begin
      run_q <= 1'b0; pix_q <= '0; line_q <= '0;
    end else if (pix_ce) begin
      if (!run_q) run_q <= en_q;
      else if (pix_q >= h_last) begin
        pix_q <= '0;
        if (line_q >= v_last) begin
          line_q <= '0;
          run_q  <= en_q;
        end else line_q <= line_q + ONE;
      end else pix_q <= pix_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (srst)   flag_q <= 1'b0;
    else if (ev_set) flag_q <= 1'b1;
    else if (clr)    flag_q <= 1'b0;
  end

  wire h_act = pix_q >= hb_end && pix_q < ha_end;
  wire v_act = line_q >= vb_end && line_q < va_end;

  assign hsync    = run_q && pix_q < hs_end;
  assign vsync    = run_q && line_q < vs_end;
  assign hblank   = !(run_q && h_act);
  assign vblank   = !(run_q && v_act);
  assign de       = !hblank && !vblank;
  assign irq      = flag_q;
  assign pix_cnt  = pix_q;
  assign line_cnt = line_q;
endmodule

// File: rtl/scan_timing_gen_chk.sv
module scan_timing_gen_chk #(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int CW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ce,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          irq,
  input logic [CW-1:0] pix_cnt,
  input logic [CW-1:0] line_cnt,
  input logic          run_q,
  input logic          ev_set,
  input logic          gie_q,
  input logic          fie_q
);
  wire wr_rst = wr_en && wr_addr == AW'(0) && wr_data[1];
  wire wr_clr = wr_en && wr_addr == AW'(8) && wr_data[0];

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (pix_cnt == '0 && line_cnt == '0));

  p_de_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hsync && !vsync));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(gie_q && fie_q));

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !ev_set && !wr_rst) |=> !irq);

  p_srst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> (pix_cnt == '0 && line_cnt == '0 && !irq && !run_q));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_ce && !wr_rst) |=> ($stable(pix_cnt) && $stable(line_cnt)));
endmodule

bind scan_timing_gen scan_timing_gen_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de), .irq(irq),
  .pix_cnt(pix_cnt), .line_cnt(line_cnt), .run_q(run_q), .ev_set(ev_set),
  .gie_q(gie_q), .fie_q(fie_q)
);

// File: tb/scan_timing_gen_tb_top.sv
module scan_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_ce = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync, vsync, hblank, vblank, de, irq;
  logic [13:0] pix_cnt, line_cnt;

  int checks = 0;
  int fails = 0;
  int ce_mode = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scan_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
    .de(de), .irq(irq), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  // Behavioural reference model
  int m_vbp, m_vfp, m_vsw, m_hbp, m_hfp, m_hsw, m_hact, m_vact, m_thr, m_sel;
  bit m_en, m_gie, m_fie, m_run, m_flag;
  int m_pix, m_line;

  function automatic int h_sync_len(); return m_hsw + 1; endfunction
  function automatic int h_act_beg();  return m_hsw + m_hbp + 2; endfunction
  function automatic int h_act_end();  return h_act_beg() + m_hact + 1; endfunction
  function automatic int h_total();    return h_act_end() + m_hfp + 1; endfunction
  function automatic int v_sync_len(); return m_vsw + 1; endfunction
  function automatic int v_act_beg();  return m_vsw + m_vbp + 2; endfunction
  function automatic int v_act_end();  return v_act_beg() + m_vact + 1; endfunction
  function automatic int v_total();    return v_act_end() + m_vfp + 1; endfunction
  function automatic int target_line();
    case (m_sel)
      0: return 0;
      1: return v_sync_len();
      2: return v_act_beg();
      default: return m_thr;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vbp = 0; m_vfp = 0; m_vsw = 0; m_hbp = 0; m_hfp = 0; m_hsw = 0;
      m_hact = 0; m_vact = 0; m_thr = 0; m_sel = 0;
      m_en = 0; m_gie = 0; m_fie = 0; m_run = 0; m_flag = 0; m_pix = 0; m_line = 0;
    end else begin
      bit sr, ev;
      sr = wr_en && wr_addr == 0 && wr_data[1];
      ev = m_run && pix_ce && m_pix == 0 && m_line == target_line() && m_gie && m_fie;
      if (sr) begin
        m_run = 0; m_pix = 0; m_line = 0; m_flag = 0;
      end else begin
        if (ev) m_flag = 1;
        else if (wr_en && wr_addr == 8 && wr_data[0]) m_flag = 0;
        if (pix_ce) begin
          if (!m_run) m_run = m_en;
          else if (m_pix >= h_total() - 1) begin
            m_pix = 0;
            if (m_line >= v_total() - 1) begin m_line = 0; m_run = m_en; end
            else m_line++;
          end else m_pix++;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          0: m_en = wr_data[0] && !wr_data[1];
          1: begin m_gie = wr_data[0]; m_fie = wr_data[1]; m_sel = int'(wr_data[3:2]); end
          2: begin m_vbp = int'(wr_data[11:0]); m_vfp = int'(wr_data[27:16]); end
          3: m_vsw = int'(wr_data[11:0]);
          4: begin m_hbp = int'(wr_data[11:0]); m_hfp = int'(wr_data[27:16]); end
          5: m_hsw = int'(wr_data[11:0]);
          6: begin m_hact = int'(wr_data[11:0]); m_vact = int'(wr_data[27:16]); end
          7: m_thr = int'(wr_data[11:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_hs, e_vs, e_ha, e_va;
      e_hs = m_run && m_pix < h_sync_len();
      e_vs = m_run && m_line < v_sync_len();
      e_ha = m_run && m_pix >= h_act_beg() && m_pix < h_act_end();
      e_va = m_run && m_line >= v_act_beg() && m_line < v_act_end();
      chk(hsync == e_hs, "R2 hsync", hsync, e_hs);
      chk(vsync == e_vs, "R2 vsync", vsync, e_vs);
      chk(hblank == !e_ha, "R3 hblank", hblank, !e_ha);
      chk(vblank == !e_va, "R3 vblank", vblank, !e_va);
      chk(de == (e_ha && e_va), "R3 de", de, e_ha && e_va);
      chk(int'(pix_cnt) == m_pix, "R4 pix_cnt", pix_cnt, m_pix);
      chk(int'(line_cnt) == m_line, "R4 line_cnt", line_cnt, m_line);
      chk(irq == m_flag, "R6 irq", irq, m_flag);
    end
  end

  initial forever begin
    @(negedge clk);
    case (ce_mode)
      0: pix_ce = 1'b1;
      1: pix_ce = 1'($urandom_range(0, 1));
      default: pix_ce = 1'b0;
    endcase
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_cnt == 0 && line_cnt == 0 && !irq && !hsync && !vsync && !de && hblank && vblank,
        "R5 reset idle", {pix_cnt, line_cnt}, 0);

    // R1: geometry vsw=1 vbp=2 vact=4 vfp=1, hsw=2 hbp=3 hact=8 hfp=2
    wr(2, {4'd0, 12'd0, 4'd0, 12'd1});
    wr(3, 32'd0);
    wr(4, {4'd0, 12'd1, 4'd0, 12'd2});
    wr(5, 32'd1);
    wr(6, {4'd0, 12'd3, 4'd0, 12'd7});
    wr(7, 32'd5);
    wr(1, 32'h3);
    repeat (10) @(negedge clk);
    chk(pix_cnt == 0 && line_cnt == 0 && !hsync, "R5 idle before run", pix_cnt, 0);

    wr(0, 32'h1);
    @(negedge clk);
    chk(hsync && vsync, "R5 start on first enable", hsync, 1);
    wait_irq();
    chk(line_cnt == 0 && pix_cnt == 1, "R7 select vsync start", line_cnt, 0);
    while (!de) @(negedge clk);
    chk(pix_cnt == 5 && line_cnt == 3, "R1 active start position", {pix_cnt, line_cnt}, {14'd5, 14'd3});

    wr(8, 32'h0);
    chk(irq, "R8 zero write ignored", irq, 1);
    wr(8, 32'h1);
    chk(!irq, "R8 clear by one", irq, 0);

    wr(1, 32'h3 | (1 << 2));
    wait_irq();
    chk(line_cnt == 1 && pix_cnt == 1, "R7 select back porch", line_cnt, 1);
    wr(8, 32'h1);
    wr(1, 32'h3 | (2 << 2));
    wait_irq();
    chk(line_cnt == 3 && pix_cnt == 1, "R7 select active", line_cnt, 3);
    wr(8, 32'h1);
    wr(1, 32'h3 | (3 << 2));
    wait_irq();
    chk(line_cnt == 5 && pix_cnt == 1, "R10 threshold line", line_cnt, 5);
    wr(8, 32'h1);

    wr(1, 32'h2);
    repeat (300) @(negedge clk);
    chk(!irq, "R6 global enable off", irq, 0);
    wr(1, 32'h1);
    repeat (300) @(negedge clk);
    chk(!irq, "R6 frame enable off", irq, 0);

    wr(1, 32'h3);
    ce_mode = 1;
    repeat (1200) @(negedge clk);
    ce_mode = 2;
    @(negedge clk);
    begin
      logic [13:0] p0, l0;
      p0 = pix_cnt; l0 = line_cnt;
      repeat (6) @(negedge clk);
      chk(pix_cnt == p0 && line_cnt == l0, "R4 hold without enable", pix_cnt, p0);
    end
    ce_mode = 0;

    while (line_cnt != 2) @(negedge clk);
    wr(0, 32'h0);
    chk(!(pix_cnt == 0 && line_cnt == 0), "R5 frame completes", line_cnt, 2);
    while (pix_cnt != 0 || line_cnt != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(pix_cnt == 0 && line_cnt == 0 && !hsync && !vsync && vblank, "R5 stopped at frame end",
        pix_cnt, 0);

    wr(0, 32'h1);
    wait_irq();
    while (line_cnt != 4) @(negedge clk);
    wr(0, 32'h3);
    chk(pix_cnt == 0 && line_cnt == 0 && !irq && !hsync, "R9 soft reset", {pix_cnt, line_cnt}, 0);
    repeat (10) @(negedge clk);
    chk(pix_cnt == 0 && !hsync && !vsync, "R9 run bit cleared", pix_cnt, 0);

    finish_run();
  end
endmodule